// File: doc/BRIEF.md
# Secure Access Filter with Violation Capture

This block sits on the path from an upstream bus master to a protected memory. The memory is divided into equal blocks, and an external configuration table holds one ownership bit per block. A set bit gives the block to the non-secure world and a clear bit gives it to the secure world. For each request the filter computes which table word and which bit cover the address. It fetches that word through a combinational lookup port and decides in the same cycle whether the request may pass. A request whose world matches the bit is forwarded downstream unchanged. Any other request is absorbed: reads return zero, writes never reach the memory, and the response is either OK or an error depending on a plain control pin.

The first rejected request after the violation status was last cleared records its full address, its master identifier, its effective world and the ownership bit it hit. It also sets the violation status. The status drives an interrupt through an enable bit. Software reads the captured details, and clears, sets or masks the status, through a small word-wide register port. Storing the table and decoding any other register space are left to the surrounding logic.

The upstream and downstream request channels are valid/ready. A forwarded request takes its ready from the memory, so downstream back-pressure stalls the master. A rejected request is accepted at once, with ready held high. Read data and the error flag are returned in the cycle the request is accepted.

Top module: `sec_filter`

## Requirements
- R1: The ownership bit for byte address A is bit ((A >> BLK_SHIFT) mod 32) of table word (A >> (BLK_SHIFT+5)). The word index is presented on `tbl_idx` in the same cycle as the request.
- R2: A request passes when its effective world equals the ownership bit, where 1 means non-secure. A passing request appears on the downstream channel with the same address, write flag and write data, and its read data is `dn_rdata`.
- R3: A request with `up_attr_valid` low is treated as secure, whatever `up_nonsec` holds.
- R4: A rejected request never raises `dn_valid`. It is accepted in its own cycle (`up_ready` high) and its read data is zero.
- R5: `up_err` is high exactly when a valid request is rejected while `err_resp_en` is 1. With `err_resp_en` at 0 a rejected request completes with an OK response.
- R6: On the clock edge that accepts a rejected request while the status is clear, the filter does two things. INFO1 (byte offset 0x2C) takes the zero-extended address. INFO2 (offset 0x30) takes the master ID in bits 15:0, the effective non-secure flag in bit 16 and the ownership bit in bit 17, with all other bits zero. The status bit (offset 0x20, bit 0) is then set.
- R7: While the status is set, further rejected requests are still blocked but leave INFO1 and INFO2 unchanged.
- R8: `irq` equals the status bit ANDed with the enable bit. The enable bit is offset 0x28, bit 0, and is read/write.
- R9: Writing a word with bit 0 set to offset 0x24 clears the status, and doing so to offset 0x34 sets it. A write with bit 0 clear to either offset does nothing. Both offsets read as zero.
- R10: If a status-clear write and a rejected request land on the same edge, the new request is captured and the status stays set.
- R11: After reset the status, INFO1 and INFO2 read 0, the enable reads 1, and `irq` is low.
- R12: A passing request has `up_ready` equal to `dn_ready`. Passing requests never change the status or the captured information.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Byte address within the protected memory |
| up_wdata | input | DATA_W | Write data |
| up_attr_valid | input | 1 | Security attribute present |
| up_nonsec | input | 1 | Request is non-secure (when attribute present) |
| up_master | input | 16 | Requesting master identifier |
| up_rdata | output | DATA_W | Read data returned to the master |
| up_err | output | 1 | Error response for a rejected request |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_rdata | input | DATA_W | Read data from memory |
| tbl_idx | output | ADDR_W-BLK_SHIFT-5 | Ownership table word index |
| tbl_word | input | 32 | Ownership table word at `tbl_idx` |
| err_resp_en | input | 1 | 1 = rejected requests answer with an error |
| reg_sel | input | 1 | Register port access strobe |
| reg_wr | input | 1 | Register port write (1) or read (0) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Violation interrupt |

## Verification
The bench probes table words at both ends of the bit range (bit 0 and bit 31) and across several words. A design that sliced the block number at the wrong point, or reversed the ownership sense, would forward the wrong world. It sends requests without a security attribute but with `up_nonsec` high; a filter that trusted that pin would pass them into non-secure blocks. A second violation while the status is set must leave the captured address alone, and a design that captured on every violation would overwrite it. A clear write that coincides with a new violation must leave the status set with the new details. A design that gave the clear priority would lose that violation and drop the interrupt. Downstream back-pressure on a passing request must stall the master without touching the status.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;

  localparam int REG_W = 32;
  localparam int MID_W = 16;

  // Register byte offsets (word granular; bits 1:0 are ignored)
  localparam logic [5:0] OFF_STATUS = 6'h20;
  localparam logic [5:0] OFF_CLEAR  = 6'h24;
  localparam logic [5:0] OFF_ENABLE = 6'h28;
  localparam logic [5:0] OFF_INFO1  = 6'h2C;
  localparam logic [5:0] OFF_INFO2  = 6'h30;
  localparam logic [5:0] OFF_SET    = 6'h34;

  typedef struct packed {
    logic [13:0]      rsvd;
    logic             own_bit;
    logic             nonsec;
    logic [MID_W-1:0] master;
  } info2_t;

  function automatic logic [3:0] word_of(input logic [5:0] off);
    return off[5:2];
  endfunction

endpackage

// File: rtl/sfilt_lookup.sv
module sfilt_lookup #(
  parameter int ADDR_W    = 16,
  parameter int BLK_SHIFT = 8
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          attr_valid,
  input  logic                          nonsec,
  output logic [ADDR_W-BLK_SHIFT-6:0]   tbl_idx,
  input  logic [31:0]                   tbl_word,
  output logic                          eff_ns,
  output logic                          own_bit,
  output logic                          pass
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [BLK_W-1:0] blk_num;
  logic [4:0]       bit_sel;

  generate
    if (BLK_SHIFT > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^addr[BLK_SHIFT-1:0];
    end
  endgenerate

  assign blk_num = addr[ADDR_W-1:BLK_SHIFT];
  assign tbl_idx = blk_num[BLK_W-1:5];
  assign bit_sel = blk_num[4:0];
  assign own_bit = tbl_word[bit_sel];
  // Missing attribute counts as secure
  assign eff_ns  = attr_valid & nonsec;
  assign pass    = (own_bit == eff_ns);

endmodule

// File: rtl/sfilt_capture.sv
module sfilt_capture
  import sfilt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             viol,
  input  logic [REG_W-1:0] v_addr,
  input  info2_t           v_info,
  input  logic             clr_req,
  input  logic             set_req,
  input  logic             en_we,
  input  logic             en_wd,
  output logic             status_q,
  output logic             en_q,
  output logic [REG_W-1:0] info1_q,
  output info2_t           info2_q,
  output logic             irq
);
  logic take;

  // A capture is allowed when nothing is held, or when software is
  // releasing the held record on this very edge.
  assign take = viol & (~status_q | clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      en_q     <= 1'b1;
      info1_q  <= '0;
      info2_q  <= '0;
    end else begin
      if (en_we) en_q <= en_wd;
      if (take) begin
        status_q <= 1'b1;
        info1_q  <= v_addr;
        info2_q  <= v_info;
      end else if (clr_req) begin
        status_q <= 1'b0;
      end else if (set_req) begin
        status_q <= 1'b1;
      end
    end
  end

  assign irq = status_q & en_q;

endmodule

// File: rtl/sfilt_regif.sv
module sfilt_regif
  import sfilt_pkg::*;
(
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [3:0]       reg_word,
  input  logic             wbit0,
  input  logic             status_q,
  input  logic             en_q,
  input  logic [REG_W-1:0] info1_q,
  input  info2_t           info2_q,
  output logic             clr_req,
  output logic             set_req,
  output logic             en_we,
  output logic             en_wd,
  output logic [REG_W-1:0] rdata
);
  logic wr_hit;

  assign wr_hit  = reg_sel & reg_wr;
  assign clr_req = wr_hit & (reg_word == word_of(OFF_CLEAR)) & wbit0;
  assign set_req = wr_hit & (reg_word == word_of(OFF_SET))   & wbit0;
  assign en_we   = wr_hit & (reg_word == word_of(OFF_ENABLE));
  assign en_wd   = wbit0;

  always_comb begin
    rdata = '0;
    if (reg_sel && !reg_wr) begin
      unique case (reg_word)
        word_of(OFF_STATUS): rdata = {{(REG_W-1){1'b0}}, status_q};
        word_of(OFF_ENABLE): rdata = {{(REG_W-1){1'b0}}, en_q};
        word_of(OFF_INFO1):  rdata = info1_q;
        word_of(OFF_INFO2):  rdata = info2_q;
        default:             rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sec_filter.sv
module sec_filter
  import sfilt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        up_valid,
  output logic                        up_ready,
  input  logic                        up_write,
  input  logic [ADDR_W-1:0]           up_addr,
  input  logic [DATA_W-1:0]           up_wdata,
  input  logic                        up_attr_valid,
  input  logic                        up_nonsec,
  input  logic [MID_W-1:0]            up_master,
  output logic [DATA_W-1:0]           up_rdata,
  output logic                        up_err,
  output logic                        dn_valid,
  input  logic                        dn_ready,
  output logic                        dn_write,
  output logic [ADDR_W-1:0]           dn_addr,
  output logic [DATA_W-1:0]           dn_wdata,
  input  logic [DATA_W-1:0]           dn_rdata,
  output logic [ADDR_W-BLK_SHIFT-6:0] tbl_idx,
  input  logic [31:0]                 tbl_word,
  input  logic                        err_resp_en,
  input  logic                        reg_sel,
  input  logic                        reg_wr,
  input  logic [5:0]                  reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  output logic                        irq
);
  logic             eff_ns, own_bit, pass, viol;
  logic             clr_req, set_req, en_we, en_wd;
  logic             status_q, en_q;
  logic [REG_W-1:0] info1_q, addr_ext;
  info2_t           info2_q, cap_info;
  logic             unused_reg;

  assign unused_reg = ^{reg_addr[1:0], reg_wdata[REG_W-1:1]};

  sfilt_lookup #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_lookup (
    .addr       (up_addr),
    .attr_valid (up_attr_valid),
    .nonsec     (up_nonsec),
    .tbl_idx    (tbl_idx),
    .tbl_word   (tbl_word),
    .eff_ns     (eff_ns),
    .own_bit    (own_bit),
    .pass       (pass)
  );

  // Request path: forward on a match, absorb otherwise
  assign dn_valid = up_valid & pass;
  assign dn_write = up_write;
  assign dn_addr  = up_addr;
  assign dn_wdata = up_wdata;
  assign up_ready = pass ? dn_ready : 1'b1;
  assign up_rdata = pass ? dn_rdata : '0;
  assign up_err   = up_valid & ~pass & err_resp_en;
  assign viol     = up_valid & ~pass;

  generate
    if (ADDR_W < REG_W) begin : g_pad
      assign addr_ext = {{(REG_W-ADDR_W){1'b0}}, up_addr};
    end else begin : g_trim
      assign addr_ext = up_addr[REG_W-1:0];
    end
  endgenerate

  always_comb begin
    cap_info         = '0;
    cap_info.master  = up_master;
    cap_info.nonsec  = eff_ns;
    cap_info.own_bit = own_bit;
  end

  sfilt_regif u_regif (
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_word (reg_addr[5:2]),
    .wbit0    (reg_wdata[0]),
    .status_q (status_q),
    .en_q     (en_q),
    .info1_q  (info1_q),
    .info2_q  (info2_q),
    .clr_req  (clr_req),
    .set_req  (set_req),
    .en_we    (en_we),
    .en_wd    (en_wd),
    .rdata    (reg_rdata)
  );

  sfilt_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .viol     (viol),
    .v_addr   (addr_ext),
    .v_info   (cap_info),
    .clr_req  (clr_req),
    .set_req  (set_req),
    .en_we    (en_we),
    .en_wd    (en_wd),
    .status_q (status_q),
    .en_q     (en_q),
    .info1_q  (info1_q),
    .info2_q  (info2_q),
    .irq      (irq)
  );

endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_attr_valid,
  input logic              up_nonsec,
  input logic              up_ready,
  input logic [DATA_W-1:0] up_rdata,
  input logic              up_err,
  input logic              dn_valid,
  input logic [31:0]       tbl_word,
  input logic              err_resp_en,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [3:0]        reg_word,
  input logic              wbit0,
  input logic              status_q,
  input logic [31:0]       info1_q,
  input logic              irq
);
  logic hit_bit, world_ns, rejected, clr_wr;

  assign hit_bit  = tbl_word[up_addr[BLK_SHIFT+4:BLK_SHIFT]];
  assign world_ns = up_attr_valid && up_nonsec;
  assign rejected = up_valid && (hit_bit != world_ns);
  assign clr_wr   = reg_sel && reg_wr && (reg_word == 4'h9) && wbit0;

  AST_BLOCK_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> (!dn_valid && up_ready)); // R4

  AST_BLOCK_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> (up_rdata == '0)); // R4

  AST_ERR_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !rejected) |-> !up_err); // R5

  AST_ERR_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected && err_resp_en) |-> up_err); // R5

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected && !status_q) |=> (info1_q[ADDR_W-1:0] == $past(up_addr))); // R6

  AST_HOLD_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected && status_q && !clr_wr) |=> $stable(info1_q)); // R7

  AST_VIOL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |=> status_q); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q |-> !irq); // R8

endmodule

bind sec_filter sec_filter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .up_valid      (up_valid),
  .up_addr       (up_addr),
  .up_attr_valid (up_attr_valid),
  .up_nonsec     (up_nonsec),
  .up_ready      (up_ready),
  .up_rdata      (up_rdata),
  .up_err        (up_err),
  .dn_valid      (dn_valid),
  .tbl_word      (tbl_word),
  .err_resp_en   (err_resp_en),
  .reg_sel       (reg_sel),
  .reg_wr        (reg_wr),
  .reg_word      (reg_addr[5:2]),
  .wbit0         (reg_wdata[0]),
  .status_q      (status_q),
  .info1_q       (info1_q),
  .irq           (irq)
);

// File: tb/sec_filter_bench.sv
module sec_filter_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int BLK_SHIFT = 8;
  localparam int IDX_W = ADDR_W - BLK_SHIFT - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 0, up_write = 0, up_attr_valid = 0, up_nonsec = 0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic [DATA_W-1:0] up_wdata = '0;
  logic [15:0] up_master = '0;
  logic up_ready, up_err, dn_valid, dn_write, irq;
  logic [DATA_W-1:0] up_rdata, dn_wdata;
  logic [ADDR_W-1:0] dn_addr;
  logic dn_ready = 1'b1;
  logic [DATA_W-1:0] dn_rdata = '0;
  logic [IDX_W-1:0] tbl_idx;
  logic [31:0] tbl_word;
  logic err_resp_en = 1'b0;
  logic reg_sel = 0, reg_wr = 0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  logic [31:0] tbl_m [8];
  assign tbl_word = tbl_m[tbl_idx];

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sec_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT)) u_sec_filter (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_attr_valid(up_attr_valid),
    .up_nonsec(up_nonsec), .up_master(up_master), .up_rdata(up_rdata),
    .up_err(up_err), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata), .tbl_idx(tbl_idx), .tbl_word(tbl_word),
    .err_resp_en(err_resp_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // {addr[15:0], attr_valid, nonsec, err_resp_en, write}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h0000, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h2000, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h2000, 1'b1, 1'b0, 1'b1, 1'b1},
    {16'h4000, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h4100, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'hFF00, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'hFE00, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h2000, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h0000, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h6300, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] off, output logic [31:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = off;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [5:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic txn(input logic [15:0] a, input logic av, input logic ns,
                     input logic [15:0] mid);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_attr_valid = av; up_nonsec = ns;
    up_master = mid; up_write = 1'b0;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    tbl_m[0] = 32'h0000_0000;
    tbl_m[1] = 32'hFFFF_FFFF;
    tbl_m[2] = 32'h0000_0001;
    tbl_m[3] = 32'h5555_5555;
    tbl_m[4] = 32'h5555_5555;
    tbl_m[5] = 32'h5555_5555;
    tbl_m[6] = 32'h5555_5555;
    tbl_m[7] = 32'h8000_0000;

    do_reset();
    #2;
    rd(6'h20, v); check("R11 status", v, 0);
    rd(6'h28, v); check("R11 enable", v, 1);
    rd(6'h2C, v); check("R11 info1", v, 0);
    rd(6'h30, v); check("R11 info2", v, 0);
    check("R11 irq", {31'b0, irq}, 0);

    // Vector walk: lookup, pass/block, response
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      logic av, ns, ee, w, own, effns, exp_pass;
      logic [IDX_W-1:0] eidx;
      {a, av, ns, ee, w} = VEC[i];
      eidx = a >> (BLK_SHIFT + 5);
      own = tbl_m[eidx][(a >> BLK_SHIFT) & 16'd31];
      effns = av & ns;
      exp_pass = (own == effns);
      @(negedge clk);
      up_valid = 1'b1; up_addr = a; up_attr_valid = av; up_nonsec = ns;
      err_resp_en = ee; up_write = w; up_wdata = 32'h1111_0000 + i;
      dn_rdata = 32'hC0DE_0000 + i; dn_ready = 1'b1;
      #2;
      check("R1 tbl_idx", {29'b0, tbl_idx}, {29'b0, eidx});
      check(av ? "R2 dn_valid" : "R3 dn_valid", {31'b0, dn_valid}, {31'b0, exp_pass});
      check("R4 up_ready", {31'b0, up_ready}, 1);
      check("R4 up_rdata", up_rdata, exp_pass ? 32'hC0DE_0000 + i : 32'h0);
      check("R5 up_err", {31'b0, up_err}, {31'b0, ~exp_pass & ee});
      if (exp_pass) begin
        check("R2 dn_addr", {16'b0, dn_addr}, {16'b0, a});
        check("R2 dn_write", {31'b0, dn_write}, {31'b0, w});
        check("R2 dn_wdata", dn_wdata, 32'h1111_0000 + i);
      end
    end
    @(negedge clk);
    up_valid = 1'b0; err_resp_en = 1'b0;

    // First capture
    do_reset();
    txn(16'h2345, 1'b1, 1'b0, 16'hBEEF);
    rd(6'h2C, v); check("R6 info1", v, 32'h0000_2345);
    rd(6'h30, v); check("R6 info2", v, 32'h0002_BEEF);
    rd(6'h20, v); check("R6 status", v, 1);
    check("R8 irq on", {31'b0, irq}, 1);

    // Second violation captures nothing
    txn(16'h0010, 1'b1, 1'b1, 16'h1234);
    rd(6'h2C, v); check("R7 info1 held", v, 32'h0000_2345);
    rd(6'h30, v); check("R7 info2 held", v, 32'h0002_BEEF);

    // Enable masking
    wr(6'h28, 32'h0);
    rd(6'h28, v); check("R8 enable off", v, 0);
    check("R8 irq masked", {31'b0, irq}, 0);
    rd(6'h20, v); check("R8 status kept", v, 1);
    wr(6'h28, 32'h1);
    check("R8 irq back", {31'b0, irq}, 1);

    // Clear / set registers
    wr(6'h24, 32'hFFFF_FFFE);
    rd(6'h20, v); check("R9 clear bit0=0 ignored", v, 1);
    wr(6'h24, 32'h1);
    rd(6'h20, v); check("R9 clear", v, 0);
    check("R9 irq after clear", {31'b0, irq}, 0);
    rd(6'h24, v); check("R9 clear reads 0", v, 0);
    rd(6'h34, v); check("R9 set reads 0", v, 0);
    wr(6'h34, 32'h0);
    rd(6'h20, v); check("R9 set bit0=0 ignored", v, 0);
    wr(6'h34, 32'h1);
    rd(6'h20, v); check("R9 set", v, 1);

    // Clear and violation on the same edge
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 6'h24; reg_wdata = 32'h1;
    up_valid = 1'b1; up_addr = 16'h0044; up_attr_valid = 1'b1;
    up_nonsec = 1'b1; up_master = 16'h0777;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; up_valid = 1'b0;
    rd(6'h20, v); check("R10 status", v, 1);
    rd(6'h2C, v); check("R10 info1", v, 32'h0000_0044);
    rd(6'h30, v); check("R10 info2", v, 32'h0001_0777);

    // Back-pressure on a passing request
    wr(6'h24, 32'h1);
    @(negedge clk);
    up_valid = 1'b1; up_addr = 16'h0000; up_attr_valid = 1'b1;
    up_nonsec = 1'b0; dn_ready = 1'b0;
    #2;
    check("R12 up_ready stalled", {31'b0, up_ready}, 0);
    check("R12 dn_valid", {31'b0, dn_valid}, 1);
    @(negedge clk);
    dn_ready = 1'b1;
    #2;
    check("R12 up_ready follows", {31'b0, up_ready}, 1);
    @(negedge clk);
    up_valid = 1'b0;
    rd(6'h20, v); check("R12 status untouched", v, 0);
    rd(6'h2C, v); check("R12 info1 untouched", v, 32'h0000_0044);

    finish_run();
  end
endmodule